// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the slave-side protocol engine of a byte-wide serial EEPROM that holds 32 KiB. It watches a clock line and a data line, both already synchronised to the system clock. It answers a fixed device select code and drives SDA only through an open-drain pull-down enable. A synchronous single-port interface connects it to the memory array: the array returns read data one system clock after the address, and it takes a write strobe together with the address and the data.

A write transaction sends a select byte with the direction bit at 0, then a two-byte word address, then up to a page of data. The data goes into an internal page buffer. A STOP then starts a self-timed programming interval. During that interval the buffered bytes are written to the array, and the bus is ignored. A read can come as a repeated START after the address bytes (random read), or straight after START (current address). It continues byte after byte while the master keeps acknowledging. A write-control input blocks all data writes while still acknowledging the select and address bytes.

Top module: `eeprom_serial_slave`

## Requirements
- R1: No command is accepted unless it follows a START (SDA falling while SCL is high). Byte clocks after reset, after a refused select, or after a read that ended with NoACK and STOP get no acknowledge.
- R2: A select byte is accepted only when its upper seven bits equal 1010000. Bit 0 chooses the direction (1 read, 0 write). An accepted select is acknowledged by pulling SDA low through the ninth clock. A select that does not match gets no acknowledge, and the engine waits for the next START.
- R3: After a write select, two address bytes follow, high byte first, each sent MSB first and each acknowledged. Bit 7 of the high byte is ignored, which gives a 15-bit byte address.
- R4: With write control low, each data byte is acknowledged and stored at the next address. The array receives no write before the STOP that ends the transaction.
- R5: Within a write, the address wraps on its low 6 bits and the upper bits stay fixed. A 65th byte therefore replaces the first byte of the same 64-byte page.
- R6: A STOP after at least one accepted data byte raises `busy` for exactly PROG_CYCLES system clocks. The interval begins while SCL and SDA are both still high after the STOP. During it, one array write is issued per distinct buffered byte.
- R7: While `busy` is high, START is not recognised and SDA is never pulled low.
- R8: With write control high, the select and address bytes are acknowledged, data bytes are not, no programming interval starts, and the array is unchanged.
- R9: A read returns bytes MSB first from consecutive addresses, wrapping from 0x7FFF to 0x0000. The master's ACK continues the read, and NoACK ends it.
- R10: A read select sent straight after START returns the byte at the address after the last byte written or read.
- R11: During and straight after reset, SDA is released, `busy` is low and no array write is issued.
- R12: The pull-down enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Synchronised serial clock line |
| sdaIn | input | 1 | Synchronised serial data line (wired level) |
| writeCtl | input | 1 | High blocks all data writes |
| sdaPullDown | output | 1 | High pulls SDA low (open-drain enable) |
| busy | output | 1 | Programming interval in progress |
| memAddr | output | ADDR_W | Array byte address |
| memRdData | input | 8 | Array read data, valid one clock after memAddr |
| memWrEn | output | 1 | Array write strobe |
| memWrData | output | 8 | Array write data |

## Verification
Two activities can overlap in time: the commit of the page buffer to the array during the programming interval, and fresh bus traffic from a master that does not wait. The bench sends a STOP and then, while `busy` is still high, a START followed by a valid select byte. It judges the result in three ways: the select must get no acknowledge, `busy` must still be high when the ninth clock is sampled, and a later read must return the data that was being committed. Elsewhere the bench sweeps a whole page, plus a wrapping 65th byte, and reads all of it back against expected contents computed from the address.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVSEL,
    ST_ADDRH,
    ST_ADDRL,
    ST_WDATA,
    ST_RDATA,
    ST_RDONE,
    ST_PROG
  } engState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic shiftIn;   // shift one received bit into the receive register
    logic loadHi;    // capture the high address byte
    logic loadPtr;   // load the address pointer from both address bytes
    logic bufClear;  // forget all buffered page bytes
    logic bufWrite;  // store the received byte into the page buffer
    logic incPtr;    // advance the pointer after a transmitted byte
    logic loadTx;    // load the transmit register from array read data
    logic shiftTx;   // move to the next transmit bit
    logic commit;    // programming interval: present one buffer slot
  } dpCtl_t;

endpackage

// File: rtl/eeprom_bus_edge.sv
module eeprom_bus_edge (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);

  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclIn;
      sdaPrev <= sdaIn;
    end
  end

  assign sclRise   = sclIn & ~sclPrev;
  assign sclFall   = ~sclIn & sclPrev;
  assign startSeen = sclIn & sclPrev & sdaPrev & ~sdaIn;
  assign stopSeen  = sclIn & sclPrev & ~sdaPrev & sdaIn;

endmodule

// File: rtl/eeprom_slave_ctrl.sv
module eeprom_slave_ctrl
  import eeprom_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ID      = 7'b1010000,
  parameter int         PAGE_BYTES  = 64,
  parameter int         PROG_CYCLES = 10000,
  localparam int        IDX_W       = $clog2(PAGE_BYTES),
  localparam int        CNT_W       = $clog2(PROG_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclRise,
  input  logic             sclFall,
  input  logic             startSeen,
  input  logic             stopSeen,
  input  logic             sdaIn,
  input  logic             writeCtl,
  input  logic [7:0]       rxByte,
  input  logic             bufAny,
  output dpCtl_t           ctl,
  output logic [IDX_W-1:0] commitIdx,
  output logic             ackOn,
  output logic             txOn,
  output logic             busy
);

  engState_t        state, nState;
  logic [3:0]       bitCnt, nBit;
  logic [CNT_W-1:0] progCnt, nProg;
  logic             nAck, nTx;
  logic             rxPhase;

  assign rxPhase   = (state == ST_DEVSEL) || (state == ST_ADDRH) ||
                     (state == ST_ADDRL)  || (state == ST_WDATA);
  assign commitIdx = progCnt[IDX_W-1:0];
  assign busy      = (state == ST_PROG);

  always_comb begin
    nState = state;
    nBit   = bitCnt;
    nAck   = ackOn;
    nTx    = txOn;
    nProg  = progCnt;
    ctl    = '0;
    if (state == ST_PROG) begin
      ctl.commit = (progCnt < CNT_W'(PAGE_BYTES));
      if (progCnt == CNT_W'(PROG_CYCLES - 1)) begin
        nState = ST_IDLE;
        nProg  = '0;
      end else begin
        nProg = progCnt + CNT_W'(1);
      end
    end else if (startSeen) begin
      nState = ST_DEVSEL;
      nBit   = '0;
      nAck   = 1'b0;
      nTx    = 1'b0;
    end else if (stopSeen) begin
      // a STOP in the middle of a read is not honoured
      if (state != ST_RDATA) begin
        nAck   = 1'b0;
        nTx    = 1'b0;
        nBit   = '0;
        nProg  = '0;
        nState = (state == ST_WDATA && bufAny) ? ST_PROG : ST_IDLE;
      end
    end else if (rxPhase) begin
      if (sclRise) begin
        if (bitCnt < 4'd8) begin
          ctl.shiftIn = 1'b1;
          nBit        = bitCnt + 4'd1;
        end else begin
          nBit = 4'd9;
        end
      end
      if (sclFall) begin
        if (bitCnt == 4'd8) begin
          unique case (state)
            ST_DEVSEL: begin
              if (rxByte[7:1] == DEV_ID) nAck = 1'b1;
              else                       nState = ST_IDLE;
            end
            ST_ADDRH: begin
              nAck       = 1'b1;
              ctl.loadHi = 1'b1;
            end
            ST_ADDRL: begin
              nAck         = 1'b1;
              ctl.loadPtr  = 1'b1;
              ctl.bufClear = 1'b1;
            end
            default: begin
              if (!writeCtl) begin
                nAck         = 1'b1;
                ctl.bufWrite = 1'b1;
              end
            end
          endcase
        end else if (bitCnt == 4'd9) begin
          nAck = 1'b0;
          nBit = '0;
          unique case (state)
            ST_DEVSEL: begin
              if (rxByte[0]) begin
                nState     = ST_RDATA;
                ctl.loadTx = 1'b1;
                nTx        = 1'b1;
              end else begin
                nState = ST_ADDRH;
              end
            end
            ST_ADDRH: nState = ST_ADDRL;
            ST_ADDRL: nState = ST_WDATA;
            default:  nState = ST_WDATA;
          endcase
        end
      end
    end else if (state == ST_RDATA) begin
      if (sclRise) begin
        if (bitCnt < 4'd8) begin
          nBit = bitCnt + 4'd1;
        end else begin
          nBit = 4'd9;
          if (sdaIn) nState = ST_RDONE;  // master NoACK
        end
      end
      if (sclFall) begin
        if (bitCnt >= 4'd1 && bitCnt <= 4'd7) begin
          ctl.shiftTx = 1'b1;
        end else if (bitCnt == 4'd8) begin
          nTx        = 1'b0;
          ctl.incPtr = 1'b1;
        end else if (bitCnt == 4'd9) begin
          nBit       = '0;
          ctl.loadTx = 1'b1;
          nTx        = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      ackOn   <= 1'b0;
      txOn    <= 1'b0;
      progCnt <= '0;
    end else begin
      state   <= nState;
      bitCnt  <= nBit;
      ackOn   <= nAck;
      txOn    <= nTx;
      progCnt <= nProg;
    end
  end

endmodule

// File: rtl/eeprom_slave_dp.sv
module eeprom_slave_dp
  import eeprom_slave_pkg::*;
#(
  parameter int  ADDR_W     = 15,
  parameter int  PAGE_BYTES = 64,
  localparam int IDX_W      = $clog2(PAGE_BYTES),
  localparam int HI_W       = ADDR_W - 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              sdaIn,
  input  logic [7:0]        memRdData,
  input  logic [IDX_W-1:0]  commitIdx,
  output logic [7:0]        rxByte,
  output logic              txBit,
  output logic              bufAny,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [7:0]        memWrData
);

  logic [7:0]            rxShift;
  logic [7:0]            txShift;
  logic [HI_W-1:0]       addrHi;
  logic [ADDR_W-1:0]     ptr;
  logic [PAGE_BYTES-1:0] bufMask;
  logic [7:0]            bufRd [PAGE_BYTES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= 8'hFF;
      addrHi  <= '0;
      ptr     <= '0;
      bufMask <= '0;
    end else begin
      if (ctl.shiftIn) rxShift <= {rxShift[6:0], sdaIn};
      if (ctl.loadHi)  addrHi  <= rxShift[HI_W-1:0];
      if (ctl.loadPtr) ptr     <= {addrHi, rxShift};
      if (ctl.bufClear) bufMask <= '0;
      if (ctl.bufWrite) begin
        bufMask[ptr[IDX_W-1:0]] <= 1'b1;
        ptr[IDX_W-1:0]          <= ptr[IDX_W-1:0] + IDX_W'(1);
      end
      if (ctl.incPtr) ptr <= ptr + ADDR_W'(1);
      if (ctl.loadTx)       txShift <= memRdData;
      else if (ctl.shiftTx) txShift <= {txShift[6:0], 1'b1};
    end
  end

  // page buffer: one byte register per slot
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gSlot
    logic [7:0] slotData;
    always_ff @(posedge clk) begin
      if (ctl.bufWrite && ptr[IDX_W-1:0] == IDX_W'(g)) slotData <= rxShift;
    end
    assign bufRd[g] = slotData;
  end

  assign rxByte    = rxShift;
  assign txBit     = txShift[7];
  assign bufAny    = |bufMask;
  assign memAddr   = ctl.commit ? {ptr[ADDR_W-1:IDX_W], commitIdx} : ptr;
  assign memWrEn   = ctl.commit & bufMask[commitIdx];
  assign memWrData = bufRd[commitIdx];

endmodule

// File: rtl/eeprom_serial_slave.sv
module eeprom_serial_slave
  import eeprom_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ID      = 7'b1010000,
  parameter int         ADDR_W      = 15,
  parameter int         PAGE_BYTES  = 64,
  parameter int         PROG_CYCLES = 10000,
  localparam int        IDX_W       = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              writeCtl,
  output logic              sdaPullDown,
  output logic              busy,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdData,
  output logic              memWrEn,
  output logic [7:0]        memWrData
);

  logic             sclRise, sclFall, startSeen, stopSeen;
  logic [7:0]       rxByte;
  logic             txBit, bufAny, ackOn, txOn;
  logic [IDX_W-1:0] commitIdx;
  dpCtl_t           ctl;

  eeprom_bus_edge uEdge (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .sclRise   (sclRise),
    .sclFall   (sclFall),
    .startSeen (startSeen),
    .stopSeen  (stopSeen)
  );

  eeprom_slave_ctrl #(
    .DEV_ID      (DEV_ID),
    .PAGE_BYTES  (PAGE_BYTES),
    .PROG_CYCLES (PROG_CYCLES)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclRise   (sclRise),
    .sclFall   (sclFall),
    .startSeen (startSeen),
    .stopSeen  (stopSeen),
    .sdaIn     (sdaIn),
    .writeCtl  (writeCtl),
    .rxByte    (rxByte),
    .bufAny    (bufAny),
    .ctl       (ctl),
    .commitIdx (commitIdx),
    .ackOn     (ackOn),
    .txOn      (txOn),
    .busy      (busy)
  );

  eeprom_slave_dp #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .sdaIn     (sdaIn),
    .memRdData (memRdData),
    .commitIdx (commitIdx),
    .rxByte    (rxByte),
    .txBit     (txBit),
    .bufAny    (bufAny),
    .memAddr   (memAddr),
    .memWrEn   (memWrEn),
    .memWrData (memWrData)
  );

  assign sdaPullDown = ackOn | (txOn & ~txBit);

endmodule

// File: rtl/eeprom_slave_chk.sv
module eeprom_slave_chk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaIn,
  input logic sdaPullDown,
  input logic busy,
  input logic memWrEn
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (!busy && !sdaPullDown && !memWrEn)); // R11

  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> busy); // R4

  AST_PROG_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (sclIn && sdaIn)); // R6

  AST_QUIET_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaPullDown); // R7

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaPullDown != $past(sdaPullDown)) |-> !sclIn); // R12

endmodule

bind eeprom_serial_slave eeprom_slave_chk uChk (
  .clk         (clk),
  .rstN        (rstN),
  .sclIn       (sclIn),
  .sdaIn       (sdaIn),
  .sdaPullDown (sdaPullDown),
  .busy        (busy),
  .memWrEn     (memWrEn)
);

// File: tb/eeprom_serial_slave_test.sv
`timescale 1ns/1ps
module eeprom_serial_slave_test;

  localparam int PROG = 300;
  localparam int H    = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclM = 1'b1;
  logic        sdaM = 1'b1;
  logic        writeCtl = 1'b0;
  logic        sdaPullDown, busy, memWrEn;
  logic [14:0] memAddr;
  logic [7:0]  memRdData = 8'h00;
  logic [7:0]  memWrData;
  logic        sdaLine;

  int total = 0;
  int bad = 0;
  int wrCount = 0;
  int r12Bad = 0;
  bit done = 0;
  logic prevPd = 1'b0;

  logic [7:0] memOv  [int];
  logic [7:0] expMem [int];

  always #4 clk = ~clk;

  assign sdaLine = sdaM & ~sdaPullDown;

  eeprom_serial_slave #(.PROG_CYCLES(PROG)) uut (
    .clk (clk), .rstN (rstN), .sclIn (sclM), .sdaIn (sdaLine),
    .writeCtl (writeCtl), .sdaPullDown (sdaPullDown), .busy (busy),
    .memAddr (memAddr), .memRdData (memRdData), .memWrEn (memWrEn),
    .memWrData (memWrData)
  );

  function automatic logic [7:0] initVal(input int a);
    return 8'(((a ^ (a >> 7)) * 5 + 1) & 255);
  endfunction

  function automatic logic [7:0] dataVal(input int seed, input int i);
    return 8'((seed * 31 + i * 7 + 3) & 255);
  endfunction

  function automatic int expOf(input int a);
    return expMem.exists(a) ? int'(expMem[a]) : int'(initVal(a));
  endfunction

  // array model: registered read, write on strobe
  always @(posedge clk) begin
    if (memWrEn) begin
      memOv[int'(memAddr)] = memWrData;
      if (rstN) wrCount++;
    end
    memRdData <= memOv.exists(int'(memAddr)) ? memOv[int'(memAddr)] : initVal(int'(memAddr));
  end

  // R12 monitor: pull-down may move only while SCL is low
  always @(posedge clk) begin
    #1;
    if (rstN && (sdaPullDown !== prevPd) && sclM) r12Bad++;
    prevPd = sdaPullDown;
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; waitClk(H);
    sclM = 1'b1; waitClk(H);
    sdaM = 1'b0; waitClk(H);
    sclM = 1'b0; waitClk(H);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitClk(H);
    sclM = 1'b1; waitClk(H);
    sdaM = 1'b1; waitClk(H);
  endtask

  task automatic clockBit(input logic b, output logic seen);
    sdaM = b;    waitClk(H);
    sclM = 1'b1; waitClk(H);
    seen = sdaLine; waitClk(H);
    sclM = 1'b0; waitClk(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recvByte(input logic mAck, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      b[i] = s;
    end
    clockBit(~mAck, s);
  endtask

  task automatic addrPhase(input int a, input string tagA);
    logic ack;
    startCond();
    sendByte(8'hA0, ack);             check("R2 write select ack", int'(ack), 1);
    sendByte(8'((a >> 8) & 255), ack); check({tagA, " high address ack"}, int'(ack), 1);
    sendByte(8'(a & 255), ack);        check({tagA, " low address ack"}, int'(ack), 1);
  endtask

  task automatic readSeq(input int a, input int n, input string tag);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recvByte(i < n - 1, b);
      check(tag, int'(b), expOf((a + i) & 32767));
    end
    stopCond();
  endtask

  task automatic randomRead(input int a, input int n, input string tag);
    logic ack;
    addrPhase(a, "R3");
    startCond();
    sendByte(8'hA1, ack); check("R9 read select ack", int'(ack), 1);
    readSeq(a, n, tag);
  endtask

  task automatic pageWrite(input int a, input int n, input int seed, input bit probe);
    logic ack;
    int acc, wr0, bc, distinct;
    addrPhase(a, writeCtl ? "R8" : "R3");
    acc = 0;
    wr0 = wrCount;
    for (int i = 0; i < n; i++) begin
      logic [7:0] v;
      v = dataVal(seed, i);
      sendByte(v, ack);
      if (writeCtl) check("R8 data refused", int'(ack), 0);
      else begin
        check("R4 data ack", int'(ack), 1);
        expMem[(a & 32704) | ((a + i) & 63)] = v;
        acc++;
      end
    end
    check("R4 no array write before STOP", wrCount - wr0, 0);
    distinct = (acc > 64) ? 64 : acc;
    sdaM = 1'b0; waitClk(H);
    sclM = 1'b1; waitClk(H);
    sdaM = 1'b1;
    if (probe) begin
      waitClk(H);
      startCond();
      sendByte(8'hA0, ack);
      check("R7 select refused while busy", int'(ack), 0);
      check("R7 still busy at probe", int'(busy), 1);
      while (busy) waitClk(1);
      stopCond();
    end else begin
      bc = 0;
      for (int k = 0; k < 8 && !busy; k++) waitClk(1);
      while (busy) begin
        bc++;
        waitClk(1);
      end
      if (acc > 0) check("R6 busy length", bc, PROG);
      else         check("R8 no programming", bc, 0);
      waitClk(H);
    end
    check(acc > 0 ? "R6 array writes" : "R8 array writes", wrCount - wr0, distinct);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    waitClk(5);
    check("R11 reset pull-down", int'(sdaPullDown), 0);
    check("R11 reset busy", int'(busy), 0);
    check("R11 reset write", int'(memWrEn), 0);
    rstN = 1'b1;
    waitClk(3);
    check("R11 after reset pull-down", int'(sdaPullDown), 0);
    check("R11 after reset busy", int'(busy), 0);

    // R1: byte clocks without START
    sclM = 1'b0; waitClk(H);
    sendByte(8'hA0, ack);
    check("R1 no START no ack", int'(ack), 0);
    stopCond();

    // R2: wrong identifiers
    startCond();
    sendByte(8'hA2, ack); check("R2 wrong id refused", int'(ack), 0);
    sendByte(8'hA0, ack); check("R1 idle after refused select", int'(ack), 0);
    stopCond();
    startCond();
    sendByte(8'h20, ack); check("R2 wrong id refused", int'(ack), 0);
    stopCond();

    // R4 / R6: short write then read back
    pageWrite(16'h1234, 3, 1, 1'b0);
    randomRead(16'h1234, 3, "R9 random read");
    startCond();
    sendByte(8'hA1, ack); check("R10 select ack", int'(ack), 1);
    readSeq(16'h1237, 2, "R10 current address read");

    // R5: wrap inside a page
    pageWrite(16'h0BFE, 4, 2, 1'b0);
    randomRead(16'h0BC0, 2, "R5 wrapped bytes");
    randomRead(16'h0BFE, 3, "R5 page edge read");

    // R5: full page plus one, swept back
    pageWrite(16'h4000, 65, 3, 1'b0);
    randomRead(16'h4000, 64, "R5 page sweep");

    // R8: write control high
    writeCtl = 1'b1;
    pageWrite(16'h1234, 2, 9, 1'b0);
    writeCtl = 1'b0;
    randomRead(16'h1234, 2, "R8 array unchanged");

    // R7: START while programming
    pageWrite(16'h2222, 2, 5, 1'b1);
    randomRead(16'h2222, 2, "R7 commit during probe");

    // R3: top address bit ignored
    randomRead(16'h9234, 1, "R3 top bit ignored");

    // R9: address roll-over
    randomRead(16'h7FFE, 4, "R9 roll-over");

    // R1: idle after NoACK + STOP
    sclM = 1'b0; waitClk(H);
    sendByte(8'hA1, ack);
    check("R1 idle after read end", int'(ack), 0);
    stopCond();

    check("R12 pull-down moved with SCL high", r12Bad, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule